// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Sequencer

This block owns every refresh-related strobe sequence for an asynchronous DRAM that sits behind a separate access controller. After reset it waits out the power-up pause, then asks for the memory bus and runs a fixed number of initialisation cycles. Each of them is a CAS-before-RAS refresh. Once these are done it raises an init-done flag. From then on an interval timer, derived from the clock rate, the row count and the retention window (16 ms, or 128 ms for the low-power part), schedules one internally addressed refresh per row interval.

Refreshes that cannot be served at once are counted as debt. When the bus is granted, all pending refreshes run back to back: CAS stays low and only RAS is cycled. A tick that arrives while the debt is already at its bound raises a sticky error flag. A low-power request switches the DRAM into self-refresh: CAS falls, then RAS falls, and both are held for at least 100 µs and for as long as the request stays high. On exit, both strobes go high for a long precharge, and a burst covering every row runs before the bus is released. The write strobe is always held high, so no refresh cycle is ever mistaken for a test-mode entry.

Top module: `dram_refresh_seq`

## Requirements
- R1: Periodic refreshes start exactly `W*CLK_KHZ/ROWS` clock cycles apart, where W is 16 or, with `LOW_POWER`=1, 128.
- R2: After reset, `bus_req` stays low and all strobes stay high for exactly `ceil(200*CLK_KHZ/1000)` cycles. `bus_req` then rises.
- R3: Once granted, exactly `INIT_CYCLES` refresh cycles run. `init_done` then rises in the cycle CAS is released, and it never falls again.
- R4: Every RAS fall is preceded by at least `CSR_CYC` cycles of CAS low. CAS is low for the whole time RAS is low. An ordinary refresh holds RAS low for exactly `RAS_CYC` cycles.
- R5: `we_n` is high in every cycle.
- R6: RAS or CAS is driven low only while `bus_req` is high and the grant is present. Without a grant, the strobes stay high and the request is held.
- R7: Pending refreshes run back to back. CAS stays low between them, and RAS is high for exactly `RP_CYC` cycles between successive falls.
- R8: The debt saturates at `DEBT_MAX`. A further tick sets `debt_err`, which stays set until reset. The following burst is `DEBT_MAX` cycles long.
- R9: Self-refresh lowers CAS, then RAS, and holds both low for at least `ceil(100*CLK_KHZ/1000)` cycles. When the request drops after that minimum, RAS rises in the first cycle in which the drop is seen.
- R10: On self-refresh exit, RAS stays high for `RPS_CYC+CSR_CYC` cycles. Exactly `ROWS` refresh cycles then run before `bus_req` falls.
- R11: At the idle decision, a low-power request takes priority over pending debt, and the debt is discarded on self-refresh entry.
- R12: `busy` is high while the block drives a strobe sequence and low while idle. `bus_req` is high whenever `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lp_req | input | 1 | Request to enter, and level to stay in, self-refresh |
| bus_gnt | input | 1 | Memory bus granted to this block |
| bus_req | output | 1 | Memory bus wanted or in use |
| busy | output | 1 | A strobe sequence is in progress |
| init_done | output | 1 | Power-up sequence complete |
| debt_err | output | 1 | Sticky: refresh debt exceeded its bound |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write strobe, held high |

## Verification
The bench builds the block with `CLK_KHZ`=500, `ROWS`=8 and `DEBT_MAX`=3. This gives a 100-cycle pause, a 50-cycle self-refresh minimum and a 1000-cycle row interval, so debt build-up, saturation and a full post-exit burst all fit in short runs. A second instance with `LOW_POWER`=1 runs at an 8000-cycle interval, which lets the 128 ms window selection be checked against the 16 ms one in the same run.

// File: rtl/rfs_pkg.sv
package rfs_pkg;

    localparam int unsigned WIN_STD_MS = 16;
    localparam int unsigned WIN_LP_MS  = 128;
    localparam int unsigned PAUSE_US   = 200;
    localparam int unsigned SR_MIN_US  = 100;

    typedef enum logic [3:0] {
        S_PAUSE,
        S_INIT_REQ,
        S_IDLE,
        S_CBR_SETUP,
        S_CBR_RAS,
        S_CBR_PRE,
        S_SR_SETUP,
        S_SR_HOLD,
        S_SR_EXIT
    } rfs_state_e;

    typedef enum logic [1:0] {
        SRC_INIT,
        SRC_DEBT,
        SRC_BURST
    } rfs_src_e;

    typedef struct packed {
        logic ras_n;
        logic cas_n;
        logic we_n;
    } rfs_pins_t;

    // microseconds to clock cycles, rounded up
    function automatic int unsigned us_to_cyc(int unsigned us, int unsigned clk_khz);
        return (us * clk_khz + 999) / 1000;
    endfunction

    // cycles between successive row refreshes
    function automatic int unsigned row_interval(int unsigned clk_khz, bit low_power,
                                                 int unsigned rows);
        int unsigned win;
        win = low_power ? WIN_LP_MS : WIN_STD_MS;
        return (win * clk_khz) / rows;
    endfunction

    function automatic int unsigned max2(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

    // bits needed to hold the value n
    function automatic int unsigned cnt_width(int unsigned n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/rfs_interval.sv
module rfs_interval
    import rfs_pkg::*;
#(
    parameter int unsigned INTERVAL = 1953,
    parameter int unsigned DEBT_MAX = 7,
    parameter int unsigned DW       = cnt_width(DEBT_MAX)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic          clear,
    input  logic          consume,
    output logic [DW-1:0] debt,
    output logic          overflow
);

    localparam int unsigned TW = cnt_width(INTERVAL - 1);

    logic [TW-1:0] tcnt;
    logic          tick;

    assign tick = run && (tcnt == TW'(INTERVAL - 1));

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            tcnt <= '0;
        end else if (run) begin
            tcnt <= tick ? '0 : tcnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            debt     <= '0;
            overflow <= 1'b0;
        end else if (clear) begin
            debt <= '0;
        end else if (tick && !consume) begin
            if (debt == DW'(DEBT_MAX)) begin
                overflow <= 1'b1;
            end else begin
                debt <= debt + 1'b1;
            end
        end else if (!tick && consume && (debt != '0)) begin
            debt <= debt - 1'b1;
        end
    end

endmodule

// File: rtl/rfs_seq.sv
module rfs_seq
    import rfs_pkg::*;
#(
    parameter int unsigned PAUSE_CYC   = 25000,
    parameter int unsigned SR_MIN_CYC  = 12500,
    parameter int unsigned INIT_CYCLES = 8,
    parameter int unsigned ROWS        = 1024,
    parameter int unsigned CSR_CYC     = 1,
    parameter int unsigned RAS_CYC     = 8,
    parameter int unsigned RP_CYC      = 6,
    parameter int unsigned RPS_CYC     = 14,
    parameter int unsigned DW          = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          lp_req,
    input  logic          bus_gnt,
    input  logic [DW-1:0] debt,
    output rfs_state_e    state,
    output logic          consume,
    output logic          timer_run,
    output logic          timer_clear,
    output logic          init_done,
    output logic          bus_req
);

    localparam int unsigned PMAX = max2(max2(max2(PAUSE_CYC, SR_MIN_CYC), max2(RAS_CYC, RP_CYC)),
                                        max2(RPS_CYC, CSR_CYC));
    localparam int unsigned PW   = cnt_width(PMAX);
    localparam int unsigned RW   = cnt_width(max2(ROWS, INIT_CYCLES));

    rfs_state_e    st_n;
    rfs_src_e      src, src_n;
    logic [PW-1:0] ph, ph_n;
    logic [RW-1:0] rem, rem_n;
    logic          in_sr, in_sr_n;
    logic          done_n;
    logic          ph_zero;
    logic          more;
    logic          take_row;

    assign ph_zero = (ph == '0);
    assign more    = (src == SRC_DEBT) ? (debt != '0) : (rem != '0);

    always_comb begin
        st_n        = state;
        ph_n        = ph_zero ? ph : ph - 1'b1;
        rem_n       = rem;
        src_n       = src;
        in_sr_n     = in_sr;
        done_n      = init_done;
        take_row    = 1'b0;
        timer_clear = 1'b0;
        case (state)
            S_PAUSE: begin
                if (ph_zero) st_n = S_INIT_REQ;
            end
            S_INIT_REQ: begin
                if (bus_gnt) begin
                    st_n  = S_CBR_SETUP;
                    ph_n  = PW'(CSR_CYC - 1);
                    src_n = SRC_INIT;
                    rem_n = RW'(INIT_CYCLES);
                end
            end
            S_IDLE: begin
                if (bus_gnt && lp_req) begin
                    st_n        = S_SR_SETUP;
                    ph_n        = PW'(CSR_CYC - 1);
                    in_sr_n     = 1'b1;
                    timer_clear = 1'b1;
                end else if (bus_gnt && (debt != '0)) begin
                    st_n  = S_CBR_SETUP;
                    ph_n  = PW'(CSR_CYC - 1);
                    src_n = SRC_DEBT;
                end
            end
            S_CBR_SETUP: begin
                if (ph_zero) begin
                    st_n     = S_CBR_RAS;
                    ph_n     = PW'(RAS_CYC - 1);
                    take_row = 1'b1;
                end
            end
            S_CBR_RAS: begin
                if (ph_zero) begin
                    st_n = S_CBR_PRE;
                    ph_n = PW'(RP_CYC - 1);
                end
            end
            S_CBR_PRE: begin
                if (ph_zero) begin
                    if (more) begin
                        st_n     = S_CBR_RAS;
                        ph_n     = PW'(RAS_CYC - 1);
                        take_row = 1'b1;
                    end else begin
                        st_n = S_IDLE;
                        if (src == SRC_INIT)  done_n  = 1'b1;
                        if (src == SRC_BURST) in_sr_n = 1'b0;
                    end
                end
            end
            S_SR_SETUP: begin
                if (ph_zero) begin
                    st_n = S_SR_HOLD;
                    ph_n = PW'(SR_MIN_CYC - 1);
                end
            end
            S_SR_HOLD: begin
                if (ph_zero && !lp_req) begin
                    st_n = S_SR_EXIT;
                    ph_n = PW'(RPS_CYC - 1);
                end
            end
            S_SR_EXIT: begin
                if (ph_zero) begin
                    st_n  = S_CBR_SETUP;
                    ph_n  = PW'(CSR_CYC - 1);
                    src_n = SRC_BURST;
                    rem_n = RW'(ROWS);
                end
            end
            default: st_n = S_IDLE;
        endcase
        if (take_row && (src != SRC_DEBT)) rem_n = rem - 1'b1;
    end

    assign consume   = take_row && (src == SRC_DEBT);
    assign timer_run = init_done && !in_sr;
    assign bus_req   = (state != S_PAUSE) &&
                       ((state != S_IDLE) || lp_req || (debt != '0));

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= S_PAUSE;
            ph        <= PW'(PAUSE_CYC - 1);
            rem       <= '0;
            src       <= SRC_INIT;
            in_sr     <= 1'b0;
            init_done <= 1'b0;
        end else begin
            state     <= st_n;
            ph        <= ph_n;
            rem       <= rem_n;
            src       <= src_n;
            in_sr     <= in_sr_n;
            init_done <= done_n;
        end
    end

endmodule

// File: rtl/rfs_pins.sv
module rfs_pins
    import rfs_pkg::*;
(
    input  rfs_state_e state,
    output rfs_pins_t  pins,
    output logic       busy
);

    always_comb begin
        pins = '{ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
        busy = 1'b1;
        case (state)
            S_CBR_SETUP: pins.cas_n = 1'b0;
            S_CBR_RAS: begin
                pins.ras_n = 1'b0;
                pins.cas_n = 1'b0;
            end
            S_CBR_PRE:   pins.cas_n = 1'b0;
            S_SR_SETUP:  pins.cas_n = 1'b0;
            S_SR_HOLD: begin
                pins.ras_n = 1'b0;
                pins.cas_n = 1'b0;
            end
            S_SR_EXIT:   busy = 1'b1;
            default:     busy = 1'b0;
        endcase
    end

endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq
    import rfs_pkg::*;
#(
    parameter int unsigned CLK_KHZ     = 125000,
    parameter bit          LOW_POWER   = 1'b0,
    parameter int unsigned ROWS        = 1024,
    parameter int unsigned INIT_CYCLES = 8,
    parameter int unsigned CSR_CYC     = 1,
    parameter int unsigned RAS_CYC     = 8,
    parameter int unsigned RP_CYC      = 6,
    parameter int unsigned RPS_CYC     = 14,
    parameter int unsigned DEBT_MAX    = 7
) (
    input  logic clk,
    input  logic rst,
    input  logic lp_req,
    input  logic bus_gnt,
    output logic bus_req,
    output logic busy,
    output logic init_done,
    output logic debt_err,
    output logic ras_n,
    output logic cas_n,
    output logic we_n
);

    localparam int unsigned INTERVAL   = row_interval(CLK_KHZ, LOW_POWER, ROWS);
    localparam int unsigned PAUSE_CYC  = us_to_cyc(PAUSE_US, CLK_KHZ);
    localparam int unsigned SR_MIN_CYC = us_to_cyc(SR_MIN_US, CLK_KHZ);
    localparam int unsigned DW         = cnt_width(DEBT_MAX);

    logic [DW-1:0] debt;
    logic          consume;
    logic          timer_run;
    logic          timer_clear;
    rfs_state_e    state;
    rfs_pins_t     pins;

    rfs_interval #(
        .INTERVAL (INTERVAL),
        .DEBT_MAX (DEBT_MAX),
        .DW       (DW)
    ) u_interval (
        .clk      (clk),
        .rst      (rst),
        .run      (timer_run),
        .clear    (timer_clear),
        .consume  (consume),
        .debt     (debt),
        .overflow (debt_err)
    );

    rfs_seq #(
        .PAUSE_CYC   (PAUSE_CYC),
        .SR_MIN_CYC  (SR_MIN_CYC),
        .INIT_CYCLES (INIT_CYCLES),
        .ROWS        (ROWS),
        .CSR_CYC     (CSR_CYC),
        .RAS_CYC     (RAS_CYC),
        .RP_CYC      (RP_CYC),
        .RPS_CYC     (RPS_CYC),
        .DW          (DW)
    ) u_seq (
        .clk         (clk),
        .rst         (rst),
        .lp_req      (lp_req),
        .bus_gnt     (bus_gnt),
        .debt        (debt),
        .state       (state),
        .consume     (consume),
        .timer_run   (timer_run),
        .timer_clear (timer_clear),
        .init_done   (init_done),
        .bus_req     (bus_req)
    );

    rfs_pins u_pins (
        .state (state),
        .pins  (pins),
        .busy  (busy)
    );

    assign ras_n = pins.ras_n;
    assign cas_n = pins.cas_n;
    assign we_n  = pins.we_n;

endmodule

// File: rtl/rfs_checker.sv
module rfs_checker #(
    parameter int unsigned RAS_CYC    = 8,
    parameter int unsigned SR_MIN_CYC = 12500
) (
    input logic clk,
    input logic rst,
    input logic bus_gnt,
    input logic bus_req,
    input logic busy,
    input logic init_done,
    input logic debt_err,
    input logic ras_n,
    input logic cas_n
);

    int unsigned low_cnt;

    always_ff @(posedge clk) begin
        if (rst) low_cnt <= 0;
        else if (!ras_n) low_cnt <= low_cnt + 1;
        else low_cnt <= 0;
    end

    AST_CAS_LEADS: assert property (@(posedge clk) disable iff (rst)
        $fell(ras_n) |-> $past(!cas_n)); // R4
    AST_CAS_HELD: assert property (@(posedge clk) disable iff (rst)
        !ras_n |-> !cas_n); // R4
    AST_RAS_LEN: assert property (@(posedge clk) disable iff (rst)
        $rose(ras_n) |-> (low_cnt == RAS_CYC || low_cnt >= SR_MIN_CYC)); // R4
    AST_STROBE_OWNED: assert property (@(posedge clk) disable iff (rst)
        (!ras_n || !cas_n) |-> (bus_req && bus_gnt)); // R6
    AST_INIT_STICKY: assert property (@(posedge clk) disable iff (rst)
        init_done |=> init_done); // R3
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        debt_err |=> debt_err); // R8
    AST_BUSY_REQ: assert property (@(posedge clk) disable iff (rst)
        busy |-> bus_req); // R12

endmodule

bind dram_refresh_seq rfs_checker #(
    .RAS_CYC    (RAS_CYC),
    .SR_MIN_CYC (SR_MIN_CYC)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_gnt   (bus_gnt),
    .bus_req   (bus_req),
    .busy      (busy),
    .init_done (init_done),
    .debt_err  (debt_err),
    .ras_n     (ras_n),
    .cas_n     (cas_n)
);

// File: tb/sim_dram_refresh_seq.sv
`timescale 1ns/1ps
module sim_dram_refresh_seq;

    localparam int unsigned CK    = 500;
    localparam int unsigned NR    = 8;
    localparam int unsigned NI    = 8;
    localparam int unsigned TCSR  = 2;
    localparam int unsigned TRAS  = 4;
    localparam int unsigned TRP   = 3;
    localparam int unsigned TRPS  = 6;
    localparam int unsigned DMAX  = 3;
    localparam int unsigned INTV0 = 16 * CK / NR;
    localparam int unsigned INTV1 = 128 * CK / NR;
    localparam int unsigned PAUSE = (200 * CK + 999) / 1000;
    localparam int unsigned SRMIN = (100 * CK + 999) / 1000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic lp0 = 1'b0;
    logic man_gnt0 = 1'b0;
    logic auto0 = 1'b0;
    logic gnt0, req0, busy0, done0, err0, ras0, cas0, we0;
    logic gnt1, req1, busy1, done1, err1, ras1, cas1, we1;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;
    bit u1_done = 1'b0;

    always #4 clk = ~clk;

    assign gnt0 = auto0 ? req0 : man_gnt0;
    assign gnt1 = req1;

    dram_refresh_seq #(
        .CLK_KHZ(CK), .LOW_POWER(1'b0), .ROWS(NR), .INIT_CYCLES(NI),
        .CSR_CYC(TCSR), .RAS_CYC(TRAS), .RP_CYC(TRP), .RPS_CYC(TRPS), .DEBT_MAX(DMAX)
    ) u0 (
        .clk(clk), .rst(rst), .lp_req(lp0), .bus_gnt(gnt0), .bus_req(req0),
        .busy(busy0), .init_done(done0), .debt_err(err0),
        .ras_n(ras0), .cas_n(cas0), .we_n(we0)
    );

    dram_refresh_seq #(
        .CLK_KHZ(CK), .LOW_POWER(1'b1), .ROWS(NR), .INIT_CYCLES(NI),
        .CSR_CYC(TCSR), .RAS_CYC(TRAS), .RP_CYC(TRP), .RPS_CYC(TRPS), .DEBT_MAX(DMAX)
    ) u1 (
        .clk(clk), .rst(rst), .lp_req(1'b0), .bus_gnt(gnt1), .bus_req(req1),
        .busy(busy1), .init_done(done1), .debt_err(err1),
        .ras_n(ras1), .cas_n(cas1), .we_n(we1)
    );

    // observation of u0 pins
    int cyc = 0;
    int nfall = 0, ncas_rise = 0;
    int last_fall = 0, prev_fall = 0;
    int last_low = 0, last_high = 0;
    int ras_low_run = 0, ras_high_run = 0, cas_low_run = 0;
    int viol_we = 0, viol_gnt = 0, viol_csr = 0, viol_cas = 0, viol_len = 0, viol_rp = 0;
    logic pras = 1'b1, pcas = 1'b1;
    int n1fall = 0, last1 = 0, prev1 = 0;
    logic pras1 = 1'b1;

    always @(negedge clk) begin
        cyc = cyc + 1;
        if (!rst) begin
            if (!ras0 && pras) begin
                nfall = nfall + 1;
                prev_fall = last_fall;
                last_fall = cyc;
                last_high = ras_high_run;
                if (cas_low_run < int'(TCSR) || cas0) viol_csr++;
                if (cas_low_run > ras_high_run && ras_high_run != int'(TRP)) viol_rp++;
            end
            if (ras0 && !pras) begin
                last_low = ras_low_run;
                if (ras_low_run != int'(TRAS) && ras_low_run < int'(SRMIN)) viol_len++;
            end
            if (cas0 && !pcas) ncas_rise++;
            if (!ras0 && cas0) viol_cas++;
            if (!we0 || !we1) viol_we++;
            if (!gnt0 && (!ras0 || !cas0)) viol_gnt++;
            ras_low_run  = ras0 ? 0 : ras_low_run + 1;
            ras_high_run = ras0 ? ras_high_run + 1 : 0;
            cas_low_run  = cas0 ? 0 : cas_low_run + 1;
            if (!ras1 && pras1) begin
                n1fall = n1fall + 1;
                prev1 = last1;
                last1 = cyc;
            end
        end
        pras = ras0;
        pcas = cas0;
        pras1 = ras1;
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step(input int n = 1);
        repeat (n) begin
            @(negedge clk);
            #1;
        end
    endtask

    task automatic wait_req(input bit level, input int limit);
        for (int i = 0; i < limit && req0 != level; i++) step();
    endtask

    task automatic wait_ras(input bit level, input int limit);
        for (int i = 0; i < limit && ras0 != level; i++) step();
    endtask

    // u1: low-power window selection
    initial begin
        for (int i = 0; i < 20000 && !done1; i++) step();
        for (int i = 0; i < 3 * INTV1 && n1fall < int'(NI) + 2; i++) step();
        chk(last1 - prev1 == int'(INTV1), "R1 low-power interval", last1 - prev1, INTV1);
        u1_done = 1'b1;
    end

    initial begin
        int k, base, cbase, h;
        step(5);
        chk(ras0 && cas0 && we0 && !req0 && !busy0 && !done0 && !err0,
            "R2 reset state", {ras0, cas0, we0, req0, busy0, done0, err0}, 7'b1110000);
        rst = 1'b0;
        k = 0;
        while (!req0 && k < int'(PAUSE) + 20) begin
            step();
            k++;
        end
        chk(k == int'(PAUSE), "R2 pause length", k, PAUSE);

        step(20);
        chk(req0 && ras0 && cas0 && !done0, "R6 wait for grant",
            {req0, ras0, cas0, done0}, 4'b1110);

        man_gnt0 = 1'b1;
        for (int i = 0; i < 500 && !done0; i++) step();
        chk(nfall == int'(NI), "R3 init cycle count", nfall, NI);
        chk(ncas_rise == 1, "R7 init cycles back to back", ncas_rise, 1);
        chk(last_low == int'(TRAS), "R4 RAS low length", last_low, TRAS);
        chk(!req0 && !busy0, "R12 idle after init", {req0, busy0}, 2'b00);
        man_gnt0 = 1'b0;
        auto0 = 1'b1;

        base = nfall;
        for (int i = 0; i < 3 * INTV0 && nfall < base + 2; i++) step();
        chk(last_fall - prev_fall == int'(INTV0), "R1 refresh interval",
            last_fall - prev_fall, INTV0);

        // debt of DMAX, served as one burst
        wait_req(1'b0, 100);
        auto0 = 1'b0;
        wait_req(1'b1, 2 * INTV0);
        step((DMAX - 1) * INTV0 + INTV0 / 2);
        chk(!err0, "R8 no error at bound", err0, 0);
        base = nfall;
        cbase = ncas_rise;
        man_gnt0 = 1'b1;
        wait_req(1'b0, 200);
        man_gnt0 = 1'b0;
        chk(nfall - base == int'(DMAX), "R7 burst length", nfall - base, DMAX);
        chk(ncas_rise - cbase == 1, "R7 CAS held through burst", ncas_rise - cbase, 1);
        chk(last_high == int'(TRP), "R7 precharge between cycles", last_high, TRP);

        // overflow
        wait_req(1'b1, 2 * INTV0);
        step(DMAX * INTV0 + INTV0 / 2);
        chk(err0, "R8 overflow flagged", err0, 1);
        base = nfall;
        man_gnt0 = 1'b1;
        wait_req(1'b0, 200);
        man_gnt0 = 1'b0;
        chk(nfall - base == int'(DMAX), "R8 saturated burst", nfall - base, DMAX);
        chk(err0, "R8 error sticky", err0, 1);

        // self-refresh with pending debt, early request drop
        wait_req(1'b1, 2 * INTV0);
        lp0 = 1'b1;
        step(5);
        base = nfall;
        man_gnt0 = 1'b1;
        wait_ras(1'b0, 50);
        chk(busy0 && req0, "R12 busy during self-refresh", {busy0, req0}, 2'b11);
        step(5);
        lp0 = 1'b0;
        wait_ras(1'b1, 4 * SRMIN);
        chk(last_low == int'(SRMIN), "R9 minimum hold", last_low, SRMIN);
        for (int i = 0; i < 100 && nfall < base + 2; i++) step();
        chk(last_high == int'(TRPS + TCSR), "R10 exit precharge", last_high, TRPS + TCSR);
        wait_req(1'b0, 500);
        man_gnt0 = 1'b0;
        chk(nfall - base == 1 + int'(NR), "R11 debt dropped, R10 full burst",
            nfall - base, 1 + NR);
        chk(!busy0, "R12 idle after burst", busy0, 0);

        // self-refresh held beyond the minimum
        auto0 = 1'b1;
        lp0 = 1'b1;
        wait_ras(1'b0, 50);
        h = int'(SRMIN) + 20;
        step(h - 1);
        lp0 = 1'b0;
        step();
        chk(ras0 && last_low == h, "R9 exit follows request", last_low, h);
        wait_req(1'b0, 500);

        chk(viol_we == 0, "R5 write strobe high", viol_we, 0);
        chk(viol_gnt == 0, "R6 strobes only with grant", viol_gnt, 0);
        chk(viol_csr == 0 && viol_cas == 0, "R4 CAS leads and covers RAS",
            viol_csr + viol_cas, 0);
        chk(viol_len == 0, "R4 RAS low lengths", viol_len, 0);
        chk(viol_rp == 0, "R7 back-to-back precharge", viol_rp, 0);

        for (int i = 0; i < 40000 && !u1_done; i++) step();
        chk(u1_done, "R1 low-power run completed", u1_done, 1);
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule